// File: doc/BRIEF.md
# Receive Frame Ring Buffer

This block takes received frames from a byte stream and parks them in a 16 KiB circular byte store. For every accepted frame it fills one entry of a ring of receive descriptors with the frame's length and its start position, then pulses a receive-end interrupt request. Software finds new frames by scanning the descriptors and drains payload words through a 32-bit read port.

A frame is taken only when three conditions all hold at its first byte. The frame count must be below its limit. The store must have room for a maximum-size frame. The next descriptor must have been handed back by software, which it does by setting the descriptor's empty flag. The host side also has a frame-count decrement strobe and a control write that carries a soft-clear bit and a byte-order mode bit. The byte-order mode applies to payload words and to 16-bit descriptor fields, in both directions.

Top module: `rx_frame_ring`

## Requirements
- R1: The store holds 16384 bytes. The write pointer and the read pointer both wrap modulo 16384.
- R2: While the frame count is 64, a new frame is dropped whole and the count stays at 64.
- R3: A new frame is dropped when the free space is below 1514 bytes. Free space is 16384 minus ((write pointer − read pointer) mod 16384). At 1512 free the frame is refused; at 1516 free it is taken.
- R4: An accepted frame moves the write pointer forward by its length rounded up to a multiple of 4, so the next frame starts word-aligned.
- R5: If the current descriptor's empty flag (status bit 15) is clear, the frame is dropped. The descriptor, the descriptor index and the write pointer stay unchanged.
- R6: Descriptor read select 0 returns the status word, 1 the exact (unrounded) frame length and 2 the pointer 0x4000 + start offset. Storing a frame clears status bit 15 and advances the index, which wraps from 63 to 0.
- R7: One clock after the last byte of an accepted frame, the frame count has gone up by one and `rxEndIrq` is high for exactly one cycle. A dropped frame raises no request.
- R8: Each `hostRdEn` cycle loads `hostRdData`, one clock later, with the word at the read pointer and moves the pointer by 4. The byte at the lowest address sits in bits 7:0.
- R9: With mode bit 1 set, payload words come out fully byte-reversed and 16-bit descriptor fields come out with their two bytes exchanged.
- R10: A control write with bit 0 set clears the descriptor index, both pointers and the frame count. A later control write with bit 0 clear changes none of them.
- R11: `frameDec` lowers the frame count by one, but never below zero. When it coincides with the last byte of an accepted frame, the count ends unchanged.
- R12: After reset every descriptor reads back as zero, so none is empty. A host descriptor write stores the 16-bit status word, which is byte-swapped first when mode bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frmStart | input | 1 | Marks the first byte of a frame |
| frmValid | input | 1 | Byte on `frmData` is valid |
| frmLast | input | 1 | Marks the final byte of a frame |
| frmData | input | 8 | Frame byte |
| frmLen | input | LEN_W (11) | Frame length in bytes, sampled with the first byte |
| hostRdEn | input | 1 | Pop one 32-bit word from the store |
| hostRdData | output | 32 | Last popped word |
| frameDec | input | 1 | Decrement the frame count |
| ctlWrEn | input | 1 | Control write strobe |
| ctlWrData | input | 2 | Bit 0 soft clear (not kept), bit 1 byte-order mode |
| descWrEn | input | 1 | Descriptor status write strobe |
| descWrIdx | input | IdxW (6) | Descriptor to write |
| descWrData | input | 16 | Status word to write |
| descRdIdx | input | IdxW (6) | Descriptor to read |
| descRdSel | input | 2 | Field select: 0 status, 1 length, 2 pointer |
| descRdData | output | 16 | Selected descriptor field |
| frameCount | output | CntW (7) | Frames held |
| rxEndIrq | output | 1 | Receive-end interrupt request pulse |

## Verification
Short frames of odd and even length, sent back to back, show whether the pointer rounding and the exact-length descriptor field are kept apart, and whether payload lanes land in the right byte order, with and without byte reversal. A frame aimed at a descriptor that was never handed back is separated from a full-count refusal by handing back that same descriptor while the count sits at 64. A run of 1500-byte frames that fills the store, followed by single-word reads, shows the free-space threshold at 1512 and at 1516 bytes, and then shows the write pointer wrapping past the end. A decrement sent together with the last byte of a frame, and decrements sent at zero, show the two count corner cases.

// File: rtl/rx_frame_ring_pkg.sv
package rx_frame_ring_pkg;

  localparam int RxBufBytes = 16384;
  localparam int RxPtrW     = $clog2(RxBufBytes);

  localparam int CtlRstBit    = 0;
  localparam int CtlSwapBit   = 1;
  localparam int DescEmptyBit = 15;

  typedef logic [RxPtrW-1:0] bufPtr_t;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_STORE,
    FR_DROP
  } frState_t;

  // strobes from control to the buffer datapath
  typedef struct packed {
    logic    clrPtrs;
    logic    byteWr;
    bufPtr_t byteOff;
    logic    commit;
    bufPtr_t advance;
    logic    popWord;
    logic    swap;
  } dpCmd_t;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [15:0] swap16(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

endpackage

// File: rtl/rx_frame_ring_ctrl.sv
module rx_frame_ring_ctrl
  import rx_frame_ring_pkg::*;
#(
  parameter int RING       = 64,
  parameter int MAX_FRAMES = 64,
  parameter int MIN_SPACE  = 1514,
  parameter int LEN_W      = 11,
  parameter logic [15:0] PTR_BASE = 16'h4000,
  localparam int IdxW = $clog2(RING),
  localparam int CntW = $clog2(MAX_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmStart,
  input  logic              frmValid,
  input  logic              frmLast,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              hostRdEn,
  input  logic              frameDec,
  input  logic              ctlWrEn,
  input  logic [1:0]        ctlWrData,
  input  logic              descWrEn,
  input  logic [IdxW-1:0]   descWrIdx,
  input  logic [15:0]       descWrData,
  input  logic [IdxW-1:0]   descRdIdx,
  input  logic [1:0]        descRdSel,
  input  bufPtr_t           wrPtr,
  input  logic [RxPtrW:0]   freeSpace,
  output dpCmd_t            cmd,
  output logic [15:0]       descRdData,
  output logic [CntW-1:0]   frameCount,
  output logic              rxEndIrq
);

  localparam logic [CntW-1:0]  CntMax   = CntW'(MAX_FRAMES);
  localparam logic [RxPtrW:0]  SpaceMin = (RxPtrW + 1)'(MIN_SPACE);
  localparam logic [IdxW-1:0]  IdxLast  = IdxW'(RING - 1);

  logic [15:0]      descStat [RING];
  logic [LEN_W-1:0] descLen  [RING];
  logic [15:0]      descPtr  [RING];

  frState_t         state, stateNext;
  logic [LEN_W-1:0] lenQ, curLen;
  bufPtr_t          byteOff, off, lenExt, lenSum;
  logic [IdxW-1:0]  descIdx, idxNext;
  logic             swapMode;
  logic             softClr, startOk, storeBeat, commit, decReq;
  logic [CntW-1:0]  cntNext;
  logic [15:0]      hostStat, rdField;

  assign softClr   = ctlWrEn && ctlWrData[CtlRstBit];
  assign startOk   = (frameCount < CntMax) && (freeSpace >= SpaceMin) &&
                     descStat[descIdx][DescEmptyBit];
  assign storeBeat = frmValid && (frmStart ? startOk : (state == FR_STORE));
  assign off       = frmStart ? '0 : byteOff;
  assign curLen    = frmStart ? frmLen : lenQ;
  assign commit    = storeBeat && frmLast && !softClr;
  assign decReq    = frameDec && !softClr;
  assign lenExt    = bufPtr_t'(curLen);
  assign lenSum    = lenExt + bufPtr_t'(3);
  assign idxNext   = (descIdx == IdxLast) ? '0 : descIdx + 1'b1;
  assign hostStat  = swapMode ? swap16(descWrData) : descWrData;

  always_comb begin
    cmd.clrPtrs = softClr;
    cmd.byteWr  = storeBeat && !softClr && (off < lenExt);
    cmd.byteOff = off;
    cmd.commit  = commit;
    cmd.advance = {lenSum[RxPtrW-1:2], 2'b00};
    cmd.popWord = hostRdEn;
    cmd.swap    = swapMode;
  end

  always_comb begin
    stateNext = state;
    if (frmValid) begin
      if (frmStart)     stateNext = frmLast ? FR_IDLE : (startOk ? FR_STORE : FR_DROP);
      else if (frmLast) stateNext = FR_IDLE;
    end
  end

  always_comb begin
    unique case ({commit, decReq})
      2'b10:   cntNext = frameCount + 1'b1;
      2'b01:   cntNext = (frameCount == '0) ? '0 : frameCount - 1'b1;
      default: cntNext = frameCount;
    endcase
  end

  always_comb begin
    unique case (descRdSel)
      2'd0:    rdField = descStat[descRdIdx];
      2'd1:    rdField = 16'(descLen[descRdIdx]);
      2'd2:    rdField = descPtr[descRdIdx];
      default: rdField = '0;
    endcase
    descRdData = swapMode ? swap16(rdField) : rdField;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= FR_IDLE;
      lenQ       <= '0;
      byteOff    <= '0;
      descIdx    <= '0;
      frameCount <= '0;
      rxEndIrq   <= 1'b0;
      swapMode   <= 1'b0;
      for (int i = 0; i < RING; i++) begin
        descStat[i] <= '0;
        descLen[i]  <= '0;
        descPtr[i]  <= '0;
      end
    end else begin
      if (ctlWrEn)  swapMode <= ctlWrData[CtlSwapBit];
      if (descWrEn) descStat[descWrIdx] <= hostStat;
      if (softClr) begin
        state      <= FR_IDLE;
        byteOff    <= '0;
        descIdx    <= '0;
        frameCount <= '0;
        rxEndIrq   <= 1'b0;
      end else begin
        state      <= stateNext;
        frameCount <= cntNext;
        rxEndIrq   <= commit;
        if (storeBeat)           byteOff <= off + bufPtr_t'(1);
        if (frmValid && frmStart) lenQ   <= frmLen;
        if (commit) begin
          descStat[descIdx][DescEmptyBit] <= 1'b0;
          descLen[descIdx] <= curLen;
          descPtr[descIdx] <= PTR_BASE + 16'(wrPtr);
          descIdx          <= idxNext;
        end
      end
    end
  end

endmodule

// File: rtl/rx_frame_ring_dp.sv
module rx_frame_ring_dp
  import rx_frame_ring_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  dpCmd_t          cmd,
  input  logic [7:0]      byteIn,
  output bufPtr_t         wrPtr,
  output logic [RxPtrW:0] freeSpace,
  output logic [31:0]     rdWord
);

  localparam int Lanes = 4;
  localparam int Words = RxBufBytes / Lanes;

  bufPtr_t          rdPtr, byteAddr, used;
  logic [3:0][7:0]  laneRd;
  logic [31:0]      rawWord;

  assign byteAddr  = wrPtr + cmd.byteOff;
  assign used      = wrPtr - rdPtr;
  assign freeSpace = (RxPtrW + 1)'(RxBufBytes) - {1'b0, used};
  assign rawWord   = laneRd;

  // one byte-wide store per lane; the lowest address feeds bits 7:0
  for (genvar ln = 0; ln < Lanes; ln++) begin : g_lane
    logic [7:0] laneMem [Words];
    always_ff @(posedge clk) begin
      if (cmd.byteWr && (byteAddr[1:0] == 2'(ln)))
        laneMem[byteAddr[RxPtrW-1:2]] <= byteIn;
    end
    assign laneRd[ln] = laneMem[rdPtr[RxPtrW-1:2]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdWord <= '0;
    end else begin
      if (cmd.popWord) rdWord <= cmd.swap ? swap32(rawWord) : rawWord;
      if (cmd.clrPtrs) begin
        wrPtr <= '0;
        rdPtr <= '0;
      end else begin
        if (cmd.commit)  wrPtr <= wrPtr + cmd.advance;
        if (cmd.popWord) rdPtr <= rdPtr + bufPtr_t'(4);
      end
    end
  end

endmodule

// File: rtl/rx_frame_ring.sv
module rx_frame_ring
  import rx_frame_ring_pkg::*;
#(
  parameter int RING       = 64,
  parameter int MAX_FRAMES = 64,
  parameter int MIN_SPACE  = 1514,
  parameter int LEN_W      = 11,
  parameter logic [15:0] PTR_BASE = 16'h4000,
  localparam int IdxW = $clog2(RING),
  localparam int CntW = $clog2(MAX_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmStart,
  input  logic             frmValid,
  input  logic             frmLast,
  input  logic [7:0]       frmData,
  input  logic [LEN_W-1:0] frmLen,
  input  logic             hostRdEn,
  output logic [31:0]      hostRdData,
  input  logic             frameDec,
  input  logic             ctlWrEn,
  input  logic [1:0]       ctlWrData,
  input  logic             descWrEn,
  input  logic [IdxW-1:0]  descWrIdx,
  input  logic [15:0]      descWrData,
  input  logic [IdxW-1:0]  descRdIdx,
  input  logic [1:0]       descRdSel,
  output logic [15:0]      descRdData,
  output logic [CntW-1:0]  frameCount,
  output logic             rxEndIrq
);

  dpCmd_t          cmd;
  bufPtr_t         wrPtr;
  logic [RxPtrW:0] freeSpace;

  rx_frame_ring_ctrl #(
    .RING(RING), .MAX_FRAMES(MAX_FRAMES), .MIN_SPACE(MIN_SPACE),
    .LEN_W(LEN_W), .PTR_BASE(PTR_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .frmStart(frmStart), .frmValid(frmValid), .frmLast(frmLast), .frmLen(frmLen),
    .hostRdEn(hostRdEn), .frameDec(frameDec),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .descWrEn(descWrEn), .descWrIdx(descWrIdx), .descWrData(descWrData),
    .descRdIdx(descRdIdx), .descRdSel(descRdSel),
    .wrPtr(wrPtr), .freeSpace(freeSpace),
    .cmd(cmd), .descRdData(descRdData),
    .frameCount(frameCount), .rxEndIrq(rxEndIrq)
  );

  rx_frame_ring_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .byteIn(frmData),
    .wrPtr(wrPtr), .freeSpace(freeSpace), .rdWord(hostRdData)
  );

endmodule

// File: rtl/rx_frame_ring_chk.sv
module rx_frame_ring_chk #(
  parameter int MAX_FRAMES = 64,
  parameter int CNT_W      = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameDec,
  input logic             ctlWrEn,
  input logic [1:0]       ctlWrData,
  input logic             hostRdEn,
  input logic [31:0]      hostRdData,
  input logic [CNT_W-1:0] frameCount,
  input logic             rxEndIrq
);

  logic clrReq;
  assign clrReq = ctlWrEn && ctlWrData[0];

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(frameCount) <= MAX_FRAMES);

  assert_irq_counts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEndIrq && !$past(frameDec)) |-> (int'(frameCount) == int'($past(frameCount)) + 1));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> (frameCount == '0) && !rxEndIrq);

  assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEndIrq && !$past(frameDec) && !$past(clrReq)) |-> $stable(frameCount));

  assert_dec_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameDec) && !rxEndIrq && !$past(clrReq) && ($past(frameCount) != '0))
      |-> (int'(frameCount) == int'($past(frameCount)) - 1));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostRdEn) |-> $stable(hostRdData));

endmodule

bind rx_frame_ring rx_frame_ring_chk #(.MAX_FRAMES(MAX_FRAMES), .CNT_W(CntW)) u_chk (
  .clk(clk), .rstN(rstN), .frameDec(frameDec), .ctlWrEn(ctlWrEn),
  .ctlWrData(ctlWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
  .frameCount(frameCount), .rxEndIrq(rxEndIrq)
);

// File: tb/test_rx_frame_ring.sv
`timescale 1ns/1ps
module test_rx_frame_ring;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmStart = 0, frmValid = 0, frmLast = 0;
  logic [7:0]  frmData = '0;
  logic [10:0] frmLen = '0;
  logic        hostRdEn = 0;
  logic [31:0] hostRdData;
  logic        frameDec = 0;
  logic        ctlWrEn = 0;
  logic [1:0]  ctlWrData = '0;
  logic        descWrEn = 0;
  logic [5:0]  descWrIdx = '0;
  logic [15:0] descWrData = '0;
  logic [5:0]  descRdIdx = '0;
  logic [1:0]  descRdSel = '0;
  logic [15:0] descRdData;
  logic [6:0]  frameCount;
  logic        rxEndIrq;

  always #4 clk = ~clk;

  rx_frame_ring i_rx_frame_ring (.*);

  int total = 0;
  int bad = 0;

  // requirement model
  logic [7:0]  mdl  [16384];
  bit          mvld [16384];
  bit          mEmpty [64];
  int          mLen [64];
  logic [15:0] mPtr [64];
  int          mWr = 0, mRd = 0, mCnt = 0, mIdx = 0;
  bit          swapM = 0;

  // scoreboard
  logic [63:0] expQ [$];
  string       tagQ [$];
  logic        rdPend = 1'b0;

  function automatic logic [31:0] bsw32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [15:0] bsw16(input logic [15:0] h);
    return {h[7:0], h[15:8]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) rdPend <= hostRdEn;

  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) begin
        chk("R8", "unexpected read", 32'd1, 32'd0);
      end else begin
        logic [63:0] it;
        string t;
        it = expQ.pop_front();
        t  = tagQ.pop_front();
        chk(t, "read word", hostRdData & it[63:32], it[31:0] & it[63:32]);
      end
    end
  end

  task automatic hostRead(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [31:0] w, m;
      @(negedge clk);
      hostRdEn = 1'b1;
      for (int b = 0; b < 4; b++) begin
        int a;
        a = (mRd + b) & 16383;
        w[b*8 +: 8] = mvld[a] ? mdl[a] : 8'h00;
        m[b*8 +: 8] = mvld[a] ? 8'hFF : 8'h00;
      end
      if (swapM) begin w = bsw32(w); m = bsw32(m); end
      expQ.push_back({m, w});
      tagQ.push_back(tag);
      mRd = (mRd + 4) & 16383;
    end
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] base, input bit decLast, input string tag);
    bit expOk;
    int usedB;
    usedB = (mWr - mRd) & 16383;
    expOk = (mCnt < 64) && ((16384 - usedB) >= 1514) && mEmpty[mIdx];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frmValid = 1'b1;
      frmStart = (i == 0);
      frmLast  = (i == len - 1);
      frmData  = base + 8'(i);
      frmLen   = 11'(len);
      frameDec = decLast && (i == len - 1);
    end
    @(negedge clk);
    chk(tag, "irq after last byte", 32'(rxEndIrq), 32'(expOk));
    frmValid = 0; frmStart = 0; frmLast = 0; frameDec = 0;
    if (expOk) begin
      for (int i = 0; i < len; i++) begin
        mdl[(mWr + i) & 16383]  = base + 8'(i);
        mvld[(mWr + i) & 16383] = 1'b1;
      end
      mLen[mIdx]   = len;
      mPtr[mIdx]   = 16'h4000 + 16'(mWr);
      mEmpty[mIdx] = 1'b0;
      mIdx = (mIdx + 1) % 64;
      mWr  = (mWr + ((len + 3) & ~3)) & 16383;
      mCnt++;
    end
    if (decLast && mCnt > 0) mCnt--;
    chk(tag, "frame count", 32'(frameCount), 32'(mCnt));
    @(negedge clk);
    chk("R7", "irq single cycle", 32'(rxEndIrq), 32'd0);
  endtask

  task automatic descMark(input int idx);
    @(negedge clk);
    descWrEn   = 1'b1;
    descWrIdx  = 6'(idx);
    descWrData = swapM ? 16'h0080 : 16'h8000;
    @(negedge clk);
    descWrEn = 1'b0;
    mEmpty[idx] = 1'b1;
  endtask

  task automatic checkDesc(input int idx, input string tag);
    for (int s = 0; s < 3; s++) begin
      logic [15:0] e;
      descRdIdx = 6'(idx);
      descRdSel = 2'(s);
      #1;
      e = (s == 0) ? (mEmpty[idx] ? 16'h8000 : 16'h0000) :
          (s == 1) ? 16'(mLen[idx]) : mPtr[idx];
      if (swapM) e = bsw16(e);
      chk(tag, $sformatf("desc %0d field %0d", idx, s), 32'(descRdData), 32'(e));
    end
  endtask

  task automatic ctlWrite(input bit rst, input bit swp);
    @(negedge clk);
    ctlWrEn   = 1'b1;
    ctlWrData = {swp, rst};
    @(negedge clk);
    ctlWrEn = 1'b0;
    swapM   = swp;
    if (rst) begin mWr = 0; mRd = 0; mCnt = 0; mIdx = 0; end
  endtask

  task automatic decOnce(input string tag);
    @(negedge clk);
    frameDec = 1'b1;
    @(negedge clk);
    frameDec = 1'b0;
    if (mCnt > 0) mCnt--;
    chk(tag, "count after decrement", 32'(frameCount), 32'(mCnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16384; i++) begin mdl[i] = '0; mvld[i] = 1'b0; end
    for (int i = 0; i < 64; i++) begin mEmpty[i] = 0; mLen[i] = 0; mPtr[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R10", "count after reset", 32'(frameCount), 32'd0);
    chk("R7", "irq after reset", 32'(rxEndIrq), 32'd0);
    chk("R8", "read data after reset", hostRdData, 32'd0);
    checkDesc(0, "R12");
    sendFrame(4, 8'hA0, 0, "R12");          // no descriptor handed back

    // basic storage, rounding, byte order
    descMark(0);
    descMark(1);
    checkDesc(0, "R12");
    sendFrame(6, 8'h10, 0, "R7");
    checkDesc(0, "R6");
    sendFrame(9, 8'h20, 0, "R7");
    checkDesc(1, "R4");
    hostRead(2, "R8");

    // byte-reversal mode
    ctlWrite(0, 1);
    chk("R10", "count kept on plain control write", 32'(frameCount), 32'(mCnt));
    hostRead(2, "R9");
    checkDesc(1, "R9");
    descMark(4);
    checkDesc(4, "R9");
    ctlWrite(0, 0);

    // descriptor not handed back
    sendFrame(5, 8'h30, 0, "R5");
    checkDesc(2, "R5");
    descMark(2);
    descMark(3);
    sendFrame(8, 8'h40, 0, "R5");
    checkDesc(2, "R5");
    hostRead(3, "R8");

    // decrement corner cases
    decOnce("R11");
    sendFrame(4, 8'h50, 1, "R11");
    decOnce("R11");
    decOnce("R11");
    decOnce("R11");
    decOnce("R11");

    // soft clear
    descMark(0);
    ctlWrite(1, 0);
    chk("R10", "count after soft clear", 32'(frameCount), 32'd0);
    sendFrame(4, 8'h60, 0, "R10");
    checkDesc(0, "R10");

    // frame-count limit and index wrap
    ctlWrite(1, 0);
    for (int i = 0; i < 64; i++) descMark(i);
    for (int i = 0; i < 64; i++) sendFrame(4, 8'(i), 0, "R2");
    chk("R2", "count at limit", 32'(frameCount), 32'd64);
    checkDesc(63, "R6");
    descMark(0);
    sendFrame(4, 8'h77, 0, "R2");
    checkDesc(0, "R2");
    decOnce("R11");
    sendFrame(4, 8'h78, 0, "R6");
    checkDesc(0, "R6");

    // free-space threshold and pointer wrap
    ctlWrite(1, 0);
    for (int i = 0; i < 13; i++) descMark(i);
    for (int i = 0; i < 10; i++) sendFrame(1500, 8'(i * 16), 0, "R3");
    sendFrame(4, 8'h90, 0, "R3");           // 1384 free
    hostRead(32, "R8");
    sendFrame(4, 8'h91, 0, "R3");           // 1512 free
    hostRead(1, "R8");
    sendFrame(1500, 8'h92, 0, "R3");        // 1516 free
    checkDesc(10, "R3");
    hostRead(375, "R1");
    sendFrame(8, 8'h93, 0, "R1");
    checkDesc(11, "R1");

    repeat (3) @(negedge clk);
    chk("R8", "scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule